// File: doc/BRIEF.md
# Flow-Through Zero-Wait Synchronous SRAM

This block is a synthesizable model of a small single-port synchronous SRAM. Its data bus can turn from read to write, or from write to read, on consecutive clock edges with no idle cycle in between. Address, control and byte strobes are registered on the rising edge. Write data for an operation arrives one enabled cycle after its address. Read data flows combinationally from the registered address through the array, so it is valid in the cycle that follows the edge that took the address.

A load cycle starts a four-beat burst from an external address. Each later advance cycle repeats the stored operation (read, write or deselect) at the next burst address. The burst order is either linear or interleaved, chosen by a static mode input. A clock enable freezes all state. Three chip selects qualify each load. Per-lane active-low strobes mask writes, and an asynchronous output enable gates the read driver. A sleep input shuts off the block after a two-edge delay and wakes it after the same delay.

The bidirectional pad is outside this block. The block returns read data on `dout_o` with a drive enable `dout_en_o`, and it takes write data on `din_i`.

Top module: `ftzw_sram`

## Requirements
- R1: At a rising edge where `cke_ni` is high, every synchronous input is ignored and all internal state, including a pending write, keeps its value.
- R2: A load cycle (`adv_i` low) is selected only when `cs1_ni`=0, `cs2_i`=1 and `cs3_ni`=0. Any other combination makes the cycle a deselect, which writes nothing and drives nothing. After reset the block is deselected.
- R3: A selected load registers `addr_i` as the burst start. With `we_ni` high it starts a read, and with `we_ni` low it starts a write whose data is taken from `din_i` at the next enabled edge.
- R4: An advance cycle (`adv_i` high) repeats the stored operation at the next of four burst addresses, varying only address bits [1:0]. With `burst_mode_i`=0, beat k uses base+k mod 4. With `burst_mode_i`=1, beat k uses base XOR k. An advance after a deselect stays deselected.
- R5: Read and write cycles may follow each other in any order with no idle cycle. During a write the block does not drive. A read loaded on the edge that commits a write to the same address returns the new data.
- R6: During a write, lane l (bits 9l+8..9l) is written only when `bw_ni[l]` is 0. All strobes high is a write abort that leaves the word unchanged.
- R7: `dout_en_o` is high only in the cycle after a read edge, and only while `oe_ni` is low. `oe_ni` acts without a clock.
- R8: Once `sleep_i` goes high, the first two edges still sample the inputs and later edges ignore them. Once `sleep_i` goes low, two more edges are ignored before sampling resumes. While `sleep_i` or its delayed copies are high, `dout_en_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset of control state |
| cke_ni | input | 1 | Clock enable, active low |
| cs1_ni | input | 1 | Chip select, active low |
| cs2_i | input | 1 | Chip select, active high |
| cs3_ni | input | 1 | Chip select, active low |
| adv_i | input | 1 | 1 = advance burst, 0 = load address |
| we_ni | input | 1 | 0 = write, 1 = read on load |
| bw_ni | input | LANES | Per-lane write strobes, active low |
| addr_i | input | ADDR_W | Word address |
| burst_mode_i | input | 1 | Static burst order, 1 = interleaved |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request |
| din_i | input | LANES*LANE_W | Write data |
| dout_o | output | LANES*LANE_W | Read data, zero when not driving |
| dout_en_o | output | 1 | Read driver enable |

## Verification
The bench uses the default parameters: 8 address bits, four lanes of 9 bits. A 256-word array is small enough to fill completely with linear write bursts and still leave budget for mixed traffic. Four lanes allow strobe patterns that write alternate lanes, so a shifted or inverted lane mapping shows up in the read-back. Two burst address bits let both orders be checked from non-zero bases, where linear and interleaved sequences differ.

// File: rtl/ftzw_pkg.sv
`timescale 1ns/1ps
package ftzw_pkg;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    OP_DESEL = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/ftzw_burst_seq.sv
`timescale 1ns/1ps
module ftzw_burst_seq #(
  parameter int CW = 2
) (
  input  logic [CW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          interleave_i,
  output logic [CW-1:0] idx_o
);
  always_comb begin
    if (interleave_i) idx_o = base_i ^ cnt_i;
    else              idx_o = base_i + cnt_i;
  end
endmodule

// File: rtl/ftzw_sleep_sync.sv
`timescale 1ns/1ps
module ftzw_sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  output logic asleep_o,
  output logic pend_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sleep_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], sleep_i};
      end
    end
  endgenerate

  assign asleep_o = sh_q[STAGES-1];
  assign pend_o   = |sh_q;
endmodule

// File: rtl/ftzw_ctrl.sv
`timescale 1ns/1ps
module ftzw_ctrl
  import ftzw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  localparam int HI_W  = ADDR_W - BURST_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               asleep_i,
  input  logic               sel_i,
  input  logic               adv_i,
  input  logic               we_ni,
  input  logic [LANES-1:0]   bw_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  output op_e                op_o,
  output logic [HI_W-1:0]    hi_o,
  output logic [BURST_W-1:0] base_o,
  output logic [BURST_W-1:0] cnt_o,
  output logic [LANES-1:0]   bw_o
);
  op_e                op_q;
  logic [HI_W-1:0]    hi_q;
  logic [BURST_W-1:0] base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [LANES-1:0]   bw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_DESEL;
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      bw_q   <= '1;
    end else if (step_i) begin
      if (asleep_i) begin
        op_q <= OP_DESEL;
        bw_q <= '1;
      end else begin
        bw_q <= bw_ni;
        if (!adv_i) begin
          if (sel_i) begin
            op_q   <= we_ni ? OP_READ : OP_WRITE;
            hi_q   <= addr_i[ADDR_W-1:BURST_W];
            base_q <= addr_i[BURST_W-1:0];
            cnt_q  <= '0;
          end else begin
            op_q <= OP_DESEL;
          end
        end else begin
          cnt_q <= cnt_q + BURST_W'(1);
        end
      end
    end
  end

  assign op_o   = op_q;
  assign hi_o   = hi_q;
  assign base_o = base_q;
  assign cnt_o  = cnt_q;
  assign bw_o   = bw_q;
endmodule

// File: rtl/ftzw_mem.sv
`timescale 1ns/1ps
module ftzw_mem #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic [LANES-1:0]  we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] arr [DEPTH];

      always_ff @(posedge clk_i) begin
        if (we_i[l]) arr[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
      end

      assign rdata_o[l*LANE_W +: LANE_W] = arr[addr_i];
    end
  endgenerate
endmodule

// File: rtl/ftzw_sram.sv
`timescale 1ns/1ps
module ftzw_sram
  import ftzw_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int LANES     = 4,
  parameter int LANE_W    = 9,
  parameter int SLEEP_LAT = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cke_ni,
  input  logic                    cs1_ni,
  input  logic                    cs2_i,
  input  logic                    cs3_ni,
  input  logic                    adv_i,
  input  logic                    we_ni,
  input  logic [LANES-1:0]        bw_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    burst_mode_i,
  input  logic                    oe_ni,
  input  logic                    sleep_i,
  input  logic [LANES*LANE_W-1:0] din_i,
  output logic [LANES*LANE_W-1:0] dout_o,
  output logic                    dout_en_o
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int HI_W   = ADDR_W - BURST_W;

  logic               sel;
  logic               asleep;
  logic               sleep_pend;
  logic               step;
  op_e                op_q;
  logic [HI_W-1:0]    hi_q;
  logic [BURST_W-1:0] base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] beat_idx;
  logic [LANES-1:0]   bw_q;
  logic [LANES-1:0]   lane_we;
  logic [ADDR_W-1:0]  cur_addr;
  logic [DATA_W-1:0]  rdata;

  assign sel  = ~cs1_ni & cs2_i & ~cs3_ni;
  assign step = ~cke_ni;

  ftzw_sleep_sync #(.STAGES(SLEEP_LAT)) u_sleep (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sleep_i  (sleep_i),
    .asleep_o (asleep),
    .pend_o   (sleep_pend)
  );

  ftzw_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step),
    .asleep_i (asleep),
    .sel_i    (sel),
    .adv_i    (adv_i),
    .we_ni    (we_ni),
    .bw_ni    (bw_ni),
    .addr_i   (addr_i),
    .op_o     (op_q),
    .hi_o     (hi_q),
    .base_o   (base_q),
    .cnt_o    (cnt_q),
    .bw_o     (bw_q)
  );

  ftzw_burst_seq #(.CW(BURST_W)) u_seq (
    .base_i       (base_q),
    .cnt_i        (cnt_q),
    .interleave_i (burst_mode_i),
    .idx_o        (beat_idx)
  );

  assign cur_addr = {hi_q, beat_idx};

  // late write: data for the registered beat is committed at the next enabled edge
  assign lane_we = {LANES{step & ~asleep & (op_q == OP_WRITE)}} & ~bw_q;

  ftzw_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (lane_we),
    .addr_i  (cur_addr),
    .wdata_i (din_i),
    .rdata_o (rdata)
  );

  assign dout_en_o = ~oe_ni & (op_q == OP_READ) & ~sleep_i & ~sleep_pend;
  assign dout_o    = dout_en_o ? rdata : '0;
endmodule

// File: rtl/ftzw_sram_chk.sv
`timescale 1ns/1ps
module ftzw_sram_chk
  import ftzw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_ni,
  input logic              adv_i,
  input logic              we_ni,
  input logic              sel,
  input logic              asleep,
  input op_e               op_q,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [ADDR_W-1:0] addr_i,
  input logic              burst_mode_i,
  input logic              oe_ni,
  input logic              sleep_i,
  input logic              dout_en_o
);
  assert_stall_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> ($stable(op_q) && $stable(cur_addr)));

  assert_desel_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !asleep && !adv_i && !sel) |=> !dout_en_o);

  assert_load_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !asleep && !adv_i && sel) |=> (cur_addr == $past(addr_i)));

  assert_linear_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !asleep && adv_i && !burst_mode_i && op_q != OP_DESEL)
      |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1
           && cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

  assert_write_no_drive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !asleep && !adv_i && sel && !we_ni) |=> !dout_en_o);

  assert_oe_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_en_o |-> !oe_ni);

  assert_sleep_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !dout_en_o);
endmodule

bind ftzw_sram ftzw_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cke_ni       (cke_ni),
  .adv_i        (adv_i),
  .we_ni        (we_ni),
  .sel          (sel),
  .asleep       (asleep),
  .op_q         (op_q),
  .cur_addr     (cur_addr),
  .addr_i       (addr_i),
  .burst_mode_i (burst_mode_i),
  .oe_ni        (oe_ni),
  .sleep_i      (sleep_i),
  .dout_en_o    (dout_en_o)
);

// File: tb/sim_ftzw_sram.sv
`timescale 1ns/1ps
module sim_ftzw_sram;
  localparam int AW = 8;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam logic [2:0] SEL  = 3'b010;  // {cs1_n, cs2, cs3_n}
  localparam logic [2:0] DSEL = 3'b110;
  localparam logic [1:0] M_DS = 2'd0, M_RD = 2'd1, M_WR = 2'd2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cke_n = 1'b1, cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
  logic          adv = 1'b0, we_n = 1'b1, mode = 1'b0, oe_n = 1'b1, slp = 1'b0;
  logic [NL-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;

  always #2.5 clk = ~clk;

  ftzw_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cke_ni(cke_n), .cs1_ni(cs1_n), .cs2_i(cs2),
    .cs3_ni(cs3_n), .adv_i(adv), .we_ni(we_n), .bw_ni(bw_n), .addr_i(addr),
    .burst_mode_i(mode), .oe_ni(oe_n), .sleep_i(slp), .din_i(din),
    .dout_o(dout), .dout_en_o(dout_en)
  );

  typedef struct {
    logic          en;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   vectors = 0;
  int   fails = 0;
  bit   done = 1'b0;

  // reference model
  logic [DW-1:0] ref_mem [1 << AW];
  logic [1:0]    m_op = M_DS;
  logic [AW-3:0] m_hi = '0;
  logic [1:0]    m_base = '0, m_cnt = '0;
  logic [NL-1:0] m_bw = '1;
  logic          m_s1 = 1'b0, m_s2 = 1'b0;

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] lo;
    lo = mode ? (m_base ^ m_cnt) : (m_base + m_cnt);
    return {m_hi, lo};
  endfunction

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return {9'(a * 7 + s), 9'(a ^ 9'h1A5), 9'(a + s * 3), 9'(~a)};
  endfunction

  task automatic drive(input logic ck_n, input logic [2:0] cs, input logic ad,
                       input logic wn, input logic [NL-1:0] bw, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic on, input logic sl,
                       input string tag);
    exp_t e;
    logic [AW-1:0] wa;
    @(posedge clk);
    #1;
    cke_n = ck_n; cs1_n = cs[2]; cs2 = cs[1]; cs3_n = cs[0];
    adv = ad; we_n = wn; bw_n = bw; addr = a; din = d; oe_n = on; slp = sl;
    e.en   = !on && (m_op == M_RD) && !sl && !m_s1 && !m_s2;
    e.data = ref_mem[m_addr()];
    e.tag  = tag;
    q.push_back(e);
    if (!ck_n) begin
      if (m_s2) begin
        m_op = M_DS;
        m_bw = '1;
      end else begin
        wa = m_addr();
        if (m_op == M_WR)
          for (int l = 0; l < NL; l++)
            if (!m_bw[l]) ref_mem[wa][l*LW +: LW] = d[l*LW +: LW];
        if (!ad) begin
          if (cs == SEL) begin
            m_op = wn ? M_RD : M_WR;
            m_hi = a[AW-1:2];
            m_base = a[1:0];
            m_cnt = 2'd0;
          end else m_op = M_DS;
        end else m_cnt = m_cnt + 2'd1;
        m_bw = bw;
      end
    end
    m_s2 = m_s1;
    m_s1 = sl;
  endtask

  task automatic idle(input logic [DW-1:0] d, input string tag);
    drive(1'b0, DSEL, 1'b0, 1'b1, '1, '0, d, 1'b0, 1'b0, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] bw,
                    input logic [DW-1:0] d, input string tag);
    drive(1'b0, SEL, 1'b0, 1'b0, bw, a, d, 1'b0, 1'b0, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    drive(1'b0, SEL, 1'b0, 1'b1, '1, a, d, 1'b0, 1'b0, tag);
  endtask

  task automatic cont(input logic [NL-1:0] bw, input logic [DW-1:0] d, input string tag);
    drive(1'b0, SEL, 1'b1, 1'b1, bw, '0, d, 1'b0, 1'b0, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      vectors++;
      if (dout_en !== cur.en || (cur.en && dout !== cur.data)) begin
        fails++;
        $display("FAIL %s: en=%0b data=%h expected en=%0b data=%h",
                 cur.tag, dout_en, dout, cur.en, cur.data);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: en=%0b data=%h expected completion", dout_en, dout);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] pd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state, nothing driven
    idle('0, "R2 reset");
    idle('0, "R2 reset");

    // R3/R4: fill whole array with linear write bursts, back to back
    mode = 1'b0;
    pd = '0;
    for (int b = 0; b < 64; b++)
      for (int j = 0; j < 4; j++) begin
        if (j == 0) wr(AW'(b * 4), '0, pd, "R3 fill load");
        else        cont('0, pd, "R4 fill advance");
        pd = pat(b * 4 + j, 1);
      end
    idle(pd, "R3 last beat");

    // R4 linear read burst from non-zero base, wraps past 4 beats
    rd(8'h12, '0, "R4 linear load");
    for (int k = 0; k < 5; k++) cont('1, '0, "R4 linear beat");
    idle('0, "R4 linear end");

    // R4 interleaved write burst then read burst
    mode = 1'b1;
    idle('0, "R4 mode switch");
    wr(8'h81, '0, '0, "R4 ilv write");
    for (int k = 0; k < 3; k++) cont('0, pat(200 + k, 5), "R4 ilv wbeat");
    idle(pat(203, 5), "R4 ilv wlast");
    rd(8'h83, '0, "R4 ilv read");
    for (int k = 0; k < 3; k++) cont('1, '0, "R4 ilv rbeat");
    rd(8'h26, '0, "R4 ilv read2");
    for (int k = 0; k < 3; k++) cont('1, '0, "R4 ilv rbeat2");
    idle('0, "R4 ilv end");
    // continued deselect stays deselected
    drive(1'b0, DSEL, 1'b1, 1'b1, '1, '0, '0, 1'b0, 1'b0, "R4 desel cont");
    drive(1'b0, DSEL, 1'b1, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R4 desel cont");
    idle(36'h0DEADBEEF, "R4 desel after");
    mode = 1'b0;
    idle('0, "R4 mode back");

    // R5 zero-wait turnaround
    wr(8'h30, '0, '0, "R5 w30");
    rd(8'h31, pat(30, 9), "R5 r31");
    wr(8'h32, '0, '0, "R5 w32");
    rd(8'h30, pat(32, 9), "R5 r30");
    rd(8'h32, '0, "R5 r32");
    wr(8'h33, '0, '0, "R5 w33");
    rd(8'h33, pat(33, 9), "R5 r33 same addr");
    wr(8'h34, '0, '0, "R5 w34");
    idle(pat(34, 9), "R5 w34 data");
    rd(8'h34, '0, "R5 r34");
    idle('0, "R5 end");

    // R6 byte strobes and abort
    wr(8'h40, 4'b1010, '0, "R6 mask write");
    rd(8'h40, '1, "R6 mask read");
    wr(8'h41, 4'b1111, '0, "R6 abort write");
    rd(8'h41, 36'h0, "R6 abort read");
    wr(8'h42, 4'b0111, '0, "R6 one lane");
    rd(8'h42, 36'h123456789, "R6 one lane read");
    idle('0, "R6 end");

    // R1 clock-enable stalls mid read burst and between write address and data
    rd(8'h50, '0, "R1 burst load");
    cont('1, '0, "R1 beat");
    drive(1'b1, DSEL, 1'b0, 1'b0, '0, 8'h99, '1, 1'b0, 1'b0, "R1 stall");
    drive(1'b1, SEL, 1'b0, 1'b0, '0, 8'h98, '1, 1'b0, 1'b0, "R1 stall");
    cont('1, '0, "R1 resume");
    cont('1, '0, "R1 resume");
    wr(8'h60, '0, '0, "R1 write addr");
    drive(1'b1, SEL, 1'b0, 1'b1, '1, 8'h61, 36'h123456789, 1'b0, 1'b0, "R1 stall data");
    drive(1'b1, SEL, 1'b0, 1'b1, '1, 8'h61, 36'h0FEDCBA98, 1'b0, 1'b0, "R1 stall data");
    rd(8'h60, pat(60, 11), "R1 write data");
    idle('0, "R1 read back");

    // R2 each chip-select disqualifier blocks a write
    drive(1'b0, 3'b110, 1'b0, 1'b0, '0, 8'h70, '0, 1'b0, 1'b0, "R2 cs1 high");
    drive(1'b0, 3'b000, 1'b0, 1'b0, '0, 8'h71, '1, 1'b0, 1'b0, "R2 cs2 low");
    drive(1'b0, 3'b011, 1'b0, 1'b0, '0, 8'h72, '1, 1'b0, 1'b0, "R2 cs3 high");
    rd(8'h70, '1, "R2 check");
    rd(8'h71, '0, "R2 check");
    rd(8'h72, '0, "R2 check");

    // R7 asynchronous output enable
    drive(1'b0, SEL, 1'b1, 1'b1, '1, '0, '0, 1'b1, 1'b0, "R7 oe high");
    drive(1'b0, SEL, 1'b1, 1'b1, '1, '0, '0, 1'b0, 1'b0, "R7 oe low");
    drive(1'b0, DSEL, 1'b0, 1'b1, '1, '0, '0, 1'b1, 1'b0, "R7 oe high");
    idle('0, "R7 end");

    // R8 sleep entry: two edges still sampled, then ignored
    rd(8'h88, '0, "R8 pre read");
    drive(1'b0, SEL, 1'b0, 1'b0, '0, 8'h94, '0, 1'b0, 1'b1, "R8 entry write");
    drive(1'b0, DSEL, 1'b0, 1'b1, '1, '0, pat(94, 13), 1'b0, 1'b1, "R8 entry data");
    drive(1'b0, SEL, 1'b0, 1'b0, '0, 8'h90, '0, 1'b0, 1'b1, "R8 ignored write");
    drive(1'b0, SEL, 1'b1, 1'b0, '0, 8'h90, '1, 1'b0, 1'b1, "R8 ignored data");
    drive(1'b0, SEL, 1'b0, 1'b1, '1, 8'h91, '1, 1'b0, 1'b1, "R8 ignored read");
    // exit: two more ignored edges
    drive(1'b0, SEL, 1'b0, 1'b0, '0, 8'h91, '0, 1'b0, 1'b0, "R8 exit ignored");
    drive(1'b0, SEL, 1'b0, 1'b0, '0, 8'h92, '1, 1'b0, 1'b0, "R8 exit ignored");
    rd(8'h90, '1, "R8 wake read");
    rd(8'h91, '0, "R8 wake read");
    rd(8'h92, '0, "R8 wake read");
    rd(8'h94, '0, "R8 entry check");
    idle('0, "R8 end");
    idle('0, "R8 end");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule